// File: doc/BRIEF.md
# Network Controller Interrupt Status Unit

This block gathers single-cycle event pulses from the receive, transmit, PHY and bus-error logic of a network controller. Each pulse sets a sticky bit in a 26-bit status register. Status bit 15 is not stored. It is a summary bit equal to the OR of the error and reset-completion band in bits 25 to 16.

Software reaches the block over a small register bus. It reads and clears the status register, sets a per-bit mask, and sets a global enable bit. The block drives one level-sensitive interrupt line. The line is high while the global enable is set and at least one masked-in status bit, including the summary bit, is set.

Status is cleared by reading it. Writing 1s to it does not clear it. An event that arrives in the same cycle as the clearing read is not lost. It stays set for the next read.

Top module: `nic_irq_status`

## Requirements
- R1: A pulse on `evt_i[k]` sets stored status bit k on the next clock edge, for k in 0..14, 16 and 20..25. The bit stays set until status is read. The positions are: 0 rx ok, 1 rx descriptor done, 2 rx error, 3 rx early, 4 rx idle, 5 rx overrun, 6 tx ok, 7 tx descriptor done, 8 tx error, 9 tx idle, 10 tx underrun, 11 statistics service, 12 software, 13 power event, 14 PHY, 16 rx status FIFO overrun, 20 target abort, 21 master abort, 22 system error, 23 parity error, 24 rx reset done, 25 tx reset done.
- R2: Pulses on `evt_i[15]` and on `evt_i[19:17]` are ignored. Bits 19..17 of status always read 0.
- R3: Bit 15 of the value returned for a status read equals the OR of returned bits 25..16.
- R4: A read of offset 0x10 (`bus_rd` high for one cycle) returns the status on `bus_rdata`, with `bus_rvalid` high, in the next cycle. The same read clears every stored status bit.
- R5: An event pulse in the cycle of a clearing status read is not part of that read's data. It is set in status afterwards.
- R6: A write to offset 0x10 leaves status unchanged.
- R7: Offset 0x14 is a 26-bit read/write mask register. Bits 31..26 read 0.
- R8: Offset 0x18 holds the global enable in bit 0. Bits 31..1 read 0.
- R9: `irq_o` is high exactly when, one cycle earlier, the enable was 1 and (status view AND mask) was nonzero. The status view includes summary bit 15.
- R10: Reads of any other offset return 0, and writes to any other offset change no register.
- R11: After reset, status, mask, enable, `irq_o`, `bus_rvalid` and `bus_rdata` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 26 | One-cycle event pulses, one per status position |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | High in the cycle after a read strobe |
| irq_o | output | 1 | Level interrupt request, registered |

## Verification
Single low-order events are read back alone. This separates per-bit latching from clearing, and a second read shows that the clear took effect.

Groups of events are mixed with the ignored positions (15 and 17..19). One upper-band error is read alone, which shows that the summary bit is derived and not latched.

One event is pulsed exactly on the clearing read. This tells a design that keeps the new event apart from one that loses it or reports it early.

The interrupt line is tried with four setups:
- an event on an unmasked bit;
- an event on a masked-off bit;
- only the summary bit masked in;
- the enable cleared.

Each setup isolates one input of the interrupt condition.

// File: rtl/nic_irq_pkg.sv
package nic_irq_pkg;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_STAT,
    SEL_MASK,
    SEL_EN
  } reg_sel_e;

  // Status positions that can latch an event: all except the summary
  // position and the reserved band.
  function automatic logic [63:0] latch_positions(input int unsigned width,
                                                  input int unsigned sum_bit,
                                                  input int unsigned rsv_lo,
                                                  input int unsigned rsv_hi);
    logic [63:0] m;
    m = '0;
    for (int unsigned i = 0; i < width; i++) begin
      if (i != sum_bit && !(i >= rsv_lo && i <= rsv_hi)) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/nic_irq_decode.sv
module nic_irq_decode
  import nic_irq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned STAT_OFS = 'h10,
  parameter int unsigned MASK_OFS = 'h14,
  parameter int unsigned EN_OFS   = 'h18
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(MASK_OFS);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(EN_OFS);

  always_comb begin
    unique case (addr)
      A_STAT:  sel = SEL_STAT;
      A_MASK:  sel = SEL_MASK;
      A_EN:    sel = SEL_EN;
      default: sel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/nic_irq_status_reg.sv
module nic_irq_status_reg #(
  parameter int unsigned        EVT_W   = 26,
  parameter int unsigned        SUM_BIT = 15,
  parameter int unsigned        HI_LO   = 16,
  parameter logic [EVT_W-1:0]   LATCH_M = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [EVT_W-1:0] evt,
  input  logic             clr,
  output logic [EVT_W-1:0] stored,
  output logic [EVT_W-1:0] view
);
  logic [EVT_W-1:0] stat_q;
  logic [EVT_W-1:0] evt_ok;
  logic             summary;

  assign evt_ok  = evt & LATCH_M;
  assign summary = |stat_q[EVT_W-1:HI_LO];

  // Events in the clearing cycle land on top of the zeroed register.
  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= (clr ? '0 : stat_q) | evt_ok;
  end

  assign stored = stat_q;

  always_comb begin
    view          = stat_q;
    view[SUM_BIT] = summary;
  end
endmodule

// File: rtl/nic_irq_ctrl_regs.sv
module nic_irq_ctrl_regs
  import nic_irq_pkg::*;
#(
  parameter int unsigned EVT_W  = 26,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  reg_sel_e          sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [EVT_W-1:0]  mask,
  output logic              en
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mask <= '0;
      en   <= 1'b0;
    end else if (wr) begin
      if (sel == SEL_MASK) mask <= wdata[EVT_W-1:0];
      if (sel == SEL_EN)   en   <= wdata[0];
    end
  end
endmodule

// File: rtl/nic_irq_line.sv
module nic_irq_line #(
  parameter int unsigned EVT_W = 26
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [EVT_W-1:0] view,
  input  logic [EVT_W-1:0] mask,
  input  logic             en,
  output logic             irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= en & (|(view & mask));
  end
endmodule

// File: rtl/nic_irq_status.sv
module nic_irq_status
  import nic_irq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned EVT_W    = 26,
  parameter int unsigned SUM_BIT  = 15,
  parameter int unsigned HI_LO    = 16,
  parameter int unsigned RSV_LO   = 17,
  parameter int unsigned RSV_HI   = 19,
  parameter int unsigned STAT_OFS = 'h10,
  parameter int unsigned MASK_OFS = 'h14,
  parameter int unsigned EN_OFS   = 'h18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [EVT_W-1:0]  evt_i,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              irq_o
);
  localparam logic [63:0]      LATCH_W = latch_positions(EVT_W, SUM_BIT, RSV_LO, RSV_HI);
  localparam logic [EVT_W-1:0] LATCH_M = LATCH_W[EVT_W-1:0];
  localparam int unsigned      PAD_W   = DATA_W - EVT_W;

  reg_sel_e         sel;
  logic [EVT_W-1:0] stat_vec;
  logic [EVT_W-1:0] stat_view;
  logic [EVT_W-1:0] mask_vec;
  logic             en_bit;
  logic             stat_clr;
  logic [EVT_W-1:0] rd_mux;

  nic_irq_decode #(
    .ADDR_W(ADDR_W), .STAT_OFS(STAT_OFS), .MASK_OFS(MASK_OFS), .EN_OFS(EN_OFS)
  ) u_dec (
    .addr(bus_addr), .sel(sel)
  );

  assign stat_clr = bus_rd && (sel == SEL_STAT);

  nic_irq_status_reg #(
    .EVT_W(EVT_W), .SUM_BIT(SUM_BIT), .HI_LO(HI_LO), .LATCH_M(LATCH_M)
  ) u_stat (
    .clk(clk), .rst(rst), .evt(evt_i), .clr(stat_clr),
    .stored(stat_vec), .view(stat_view)
  );

  nic_irq_ctrl_regs #(
    .EVT_W(EVT_W), .DATA_W(DATA_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .wr(bus_wr), .sel(sel), .wdata(bus_wdata),
    .mask(mask_vec), .en(en_bit)
  );

  nic_irq_line #(
    .EVT_W(EVT_W)
  ) u_line (
    .clk(clk), .rst(rst), .view(stat_view), .mask(mask_vec), .en(en_bit),
    .irq(irq_o)
  );

  always_comb begin
    unique case (sel)
      SEL_STAT: rd_mux = stat_view;
      SEL_MASK: rd_mux = mask_vec;
      SEL_EN:   rd_mux = {{(EVT_W-1){1'b0}}, en_bit};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      bus_rdata  <= bus_rd ? {{PAD_W{1'b0}}, rd_mux} : '0;
    end
  end
endmodule

// File: rtl/nic_irq_checker.sv
module nic_irq_checker
  import nic_irq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned EVT_W    = 26,
  parameter int unsigned SUM_BIT  = 15,
  parameter int unsigned HI_LO    = 16,
  parameter int unsigned RSV_LO   = 17,
  parameter int unsigned RSV_HI   = 19,
  parameter int unsigned STAT_OFS = 'h10
) (
  input logic              clk,
  input logic              rst,
  input logic [EVT_W-1:0]  evt_i,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_rvalid,
  input logic              irq_o,
  input logic [EVT_W-1:0]  stat_vec,
  input logic [EVT_W-1:0]  mask_vec,
  input logic              en_bit
);
  localparam logic [63:0]       LW = latch_positions(EVT_W, SUM_BIT, RSV_LO, RSV_HI);
  localparam logic [EVT_W-1:0]  VM = LW[EVT_W-1:0];
  localparam logic [ADDR_W-1:0] AS = ADDR_W'(STAT_OFS);

  logic             last_was_stat;
  logic [EVT_W-1:0] ev_ok;
  logic [EVT_W-1:0] chk_view;

  assign ev_ok = evt_i & VM;

  always_comb begin
    chk_view          = stat_vec;
    chk_view[SUM_BIT] = |stat_vec[EVT_W-1:HI_LO];
  end

  always_ff @(posedge clk) begin
    if (rst) last_was_stat <= 1'b0;
    else     last_was_stat <= bus_rd && (bus_addr == AS);
  end

  // R1 and R5: a latchable event is always present after its edge.
  p_event_sticks_r1: assert property (@(posedge clk) disable iff (rst)
    (|ev_ok) |=> ((stat_vec & $past(ev_ok)) == $past(ev_ok)));

  // R2: reserved and summary positions are never stored.
  p_reserved_clear_r2: assert property (@(posedge clk) disable iff (rst)
    (stat_vec & ~VM) == '0);

  // R3: the summary bit in returned data matches the upper band.
  p_summary_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_rvalid && last_was_stat) |-> (bus_rdata[SUM_BIT] == |bus_rdata[EVT_W-1:HI_LO]));

  // R4: a status read with no new events leaves nothing stored.
  p_read_clears_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == AS && !(|ev_ok)) |=> (stat_vec == '0));

  // R6: a status write alone changes nothing.
  p_write_ignored_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_rd && bus_addr == AS && !(|ev_ok)) |=> $stable(stat_vec));

  // R9: enable low forces the line low one cycle later.
  p_irq_gated_r9: assert property (@(posedge clk) disable iff (rst)
    !en_bit |=> !irq_o);

  // R9: an enabled, masked-in status raises the line one cycle later.
  p_irq_raised_r9: assert property (@(posedge clk) disable iff (rst)
    (en_bit && |(chk_view & mask_vec)) |=> irq_o);
endmodule

bind nic_irq_status nic_irq_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .EVT_W(EVT_W), .SUM_BIT(SUM_BIT),
  .HI_LO(HI_LO), .RSV_LO(RSV_LO), .RSV_HI(RSV_HI), .STAT_OFS(STAT_OFS)
) u_chk (
  .clk(clk), .rst(rst), .evt_i(evt_i), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
  .irq_o(irq_o), .stat_vec(stat_vec), .mask_vec(mask_vec), .en_bit(en_bit)
);

// File: tb/tb_nic_irq_status.sv
module tb_nic_irq_status;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [25:0] evt_i = '0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  logic [25:0] m_stat = '0;
  logic [25:0] m_mask = '0;
  logic        m_en   = 1'b0;

  always #5 clk = ~clk;

  nic_irq_status dut (
    .clk(clk), .rst(rst), .evt_i(evt_i), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .irq_o(irq_o)
  );

  function automatic logic [25:0] keep_mask();
    logic [25:0] m = '0;
    for (int i = 0; i < 26; i++) m[i] = (i != 15) && !(i >= 17 && i <= 19);
    return m;
  endfunction

  function automatic logic [25:0] with_sum(input logic [25:0] s);
    logic [25:0] v = s;
    v[15] = |s[25:16];
    return v;
  endfunction

  task automatic note(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected value for each returned read.
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        note(1'b0, "unexpected read data", bus_rdata, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        note(bus_rdata === e, t, bus_rdata, e);
      end
    end
  end

  task automatic pulse(input logic [25:0] ev);
    @(posedge clk); #1;
    evt_i = ev;
    m_stat = m_stat | (ev & keep_mask());
    @(posedge clk); #1;
    evt_i = '0;
  endtask

  task automatic rd(input logic [7:0] a, input string tag, input logic [25:0] ev = '0);
    logic [31:0] e;
    @(posedge clk); #1;
    bus_addr = a;
    bus_rd = 1'b1;
    evt_i = ev;
    case (a)
      8'h10:   begin e = {6'b0, with_sum(m_stat)}; m_stat = ev & keep_mask(); end
      8'h14:   begin e = {6'b0, m_mask}; m_stat = m_stat | (ev & keep_mask()); end
      8'h18:   begin e = {31'b0, m_en};  m_stat = m_stat | (ev & keep_mask()); end
      default: begin e = 32'h0;          m_stat = m_stat | (ev & keep_mask()); end
    endcase
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(posedge clk); #1;
    bus_rd = 1'b0;
    evt_i = '0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_addr = a;
    bus_wr = 1'b1;
    bus_wdata = d;
    if (a == 8'h14) m_mask = d[25:0];
    if (a == 8'h18) m_en = d[0];
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic chk_irq(input string tag);
    logic e;
    repeat (2) @(posedge clk);
    @(negedge clk);
    e = m_en & (|(with_sum(m_stat) & m_mask));
    note(irq_o === e, tag, {31'b0, irq_o}, {31'b0, e});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    note(irq_o === 1'b0, "R11 irq after reset", {31'b0, irq_o}, 32'h0);
    note(bus_rvalid === 1'b0 && bus_rdata === 32'h0, "R11 bus idle after reset",
         bus_rdata, 32'h0);
    rd(8'h10, "R11 status reset");
    rd(8'h14, "R11 mask reset");
    rd(8'h18, "R11 enable reset");

    // R1 / R4: single event, read, then an empty re-read.
    pulse(26'h1);
    rd(8'h10, "R1 rx ok latched");
    rd(8'h10, "R4 read cleared status");

    // R1 / R2: a mix of events including ignored positions.
    pulse(26'h0004_4A0);
    pulse((26'h1 << 15) | (26'h1 << 17) | (26'h1 << 19) | (26'h1 << 14));
    rd(8'h10, "R2 ignored positions absent");

    // R3: upper-band error sets the summary bit.
    pulse(26'h1 << 22);
    rd(8'h10, "R3 summary from system error");
    pulse(26'h1 << 25);
    rd(8'h10, "R3 summary from tx reset done");

    // R5: an event on the clearing read is kept for later.
    pulse(26'h1 << 2);
    rd(8'h10, "R5 read with coincident event", 26'h1 << 6);
    rd(8'h10, "R5 coincident event kept");

    // R6: a status write has no effect.
    pulse(26'h1 << 3);
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, "R6 status write ignored");

    // R7 / R8: mask and enable widths.
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h14, "R7 mask width");
    wr(8'h18, 32'hFFFF_FFFF);
    rd(8'h18, "R8 enable width");

    // R10: unmapped offset.
    wr(8'h1C, 32'h0000_0000);
    rd(8'h1C, "R10 unmapped reads zero");
    rd(8'h14, "R10 unmapped write left mask");

    // R9: interrupt line cases.
    wr(8'h14, 32'h1);
    wr(8'h18, 32'h1);
    pulse(26'h1 << 1);
    chk_irq("R9 masked-off event no irq");
    pulse(26'h1);
    chk_irq("R9 masked-in event irq");
    rd(8'h10, "R9 drain status");
    chk_irq("R9 irq falls after read");
    wr(8'h14, 32'h1 << 15);
    pulse(26'h1 << 23);
    chk_irq("R9 summary bit raises irq");
    wr(8'h18, 32'h0);
    chk_irq("R9 enable off drops irq");
    rd(8'h10, "R3 parity error summary");

    repeat (4) @(posedge clk);
    if (exp_q.size() != 0) note(1'b0, "scoreboard not drained", exp_q.size(), 32'h0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule